// File: doc/BRIEF.md
# Half-Flash Converter Sequencer

This block is the digital sequencer of a two-step, half-flash 8-bit converter. Two comparator banks feed it. The coarse bank and the fine bank each deliver a 15-bit thermometer vector, and a single over-range comparator supplies one more bit. The block turns each thermometer vector into a 4-bit code. It captures the coarse code as the upper nibble and the fine code as the lower nibble of an output register, and it records the over-range bit when a conversion finishes.

A host controls the block through active-low chip-select, read and write strobes and a mode pin. In write-then-read mode, a write pulse defines the tracking window. After the rising write edge, a cycle-counted fine delay completes the conversion, unless an early read completes it sooner. In read-only mode, a read strobe starts a conversion whose tracking and fine phases are both counted internally. During that conversion a ready line pulls low to hold the host. An active-low completion flag goes low when each conversion ends, and the data bus is driven only while the host reads.

All strobes are sampled on the free-running clock, and edges are detected one clock after the pin changes. The host interface is a set of plain strobe and status pins, with no valid/ready handshake and no back-pressure. The host keeps the timing.

Top module: `hfadc_ctrl`

## Requirements
- R1: While reset is held, `int_n` is 1, `rdy_pull` is 0, `ovf` is 0 and `data` is 0x00.
- R2: Each thermometer vector is encoded as (index of its highest set bit) + 1, with bit 0 at index 0. An all-zero vector gives 0. A valid thermometer code therefore encodes to its count of ones, and a malformed one, for example 0x0043, gives 7. The coarse code occupies `data[7:4]` and the fine code occupies `data[3:0]`.
- R3: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. This enable follows the pins with no clock delay.
- R4: With `mode`=1 and `cs_n`=0, a falling `wr_n` starts a conversion. At the clock edge that detects `wr_n` rising, the coarse code is latched into `data[7:4]` while `data[3:0]` keeps its old value.
- R5: In mode 1, the fine code is latched into `data[3:0]` and `int_n` goes to 0 at the edge FINE_CYC clock edges after the edge that detected `wr_n` rising. Before that edge `int_n` stays 1.
- R6: In mode 1, a falling `rd_n` with `cs_n`=0 during the fine phase completes the conversion at the edge that detects it. That conversion then produces no later completion.
- R7: `int_n` returns to 1 at the edge that detects a rising `cs_n` or a rising `rd_n`.
- R8: With `mode`=0 and `cs_n`=0, a falling `rd_n` starts a conversion, detected at edge P. The coarse code is latched at edge P+TRACK_CYC, and completion (fine code latched, `int_n` to 0) happens at edge P+TRACK_CYC+FINE_CYC.
- R9: With `mode`=0, `rdy_pull` (1 means the open-drain ready line is pulled low) goes to 1 at the edge that detects `cs_n` falling. It returns to 0 at completion or at the edge that detects `cs_n` rising.
- R10: `ovf` takes the value of `over_rng` at the completion edge and holds it until the next completion.
- R11: With `wr_n` and `rd_n` tied together in mode 1, each low strobe shows the previous result on the bus and starts a new conversion.
- R12: Strobes are ignored while `cs_n` is 1. No conversion starts, `int_n` stays 1, and `data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 selects read-only mode, 1 selects write-then-read mode |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe (mode 1 only) |
| coarse_therm | input | 15 | Coarse comparator thermometer vector |
| fine_therm | input | 15 | Fine comparator thermometer vector |
| over_rng | input | 1 | Over-range comparator output |
| data | output | 8 | Result register, coarse nibble high |
| data_oe | output | 1 | Bus drive enable; the bus is high impedance when 0 |
| int_n | output | 1 | Active-low completion flag |
| rdy_pull | output | 1 | 1 pulls the open-drain ready line low |
| ovf | output | 1 | Over-range result of the last conversion |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one fine-delay window. It appears as an `int_n` fall that comes too early, too late or twice, or as a nibble that changes at the wrong edge. Those edges are counted exactly from the detecting clock. An encoder fault appears in the very next completed byte. A mis-latched over-range flag or a ready release at the wrong time is visible at the completion edge itself. Ignored strobes are checked by waiting past a full conversion time and confirming that the result byte and the completion flag have not moved.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TRACK = 2'd1,
    PH_FINE  = 2'd2
  } phase_e;

  // strobe vector positions inside the edge detector
  localparam int unsigned SB_CS = 0;
  localparam int unsigned SB_RD = 1;
  localparam int unsigned SB_WR = 2;
  localparam int unsigned SB_N  = 3;
endpackage

// File: rtl/therm_enc.sv
module therm_enc #(
  parameter int unsigned TW = 15,
  localparam int unsigned CW = $clog2(TW + 1)
) (
  input  logic [TW-1:0] therm,
  output logic [CW-1:0] code
);
  logic [TW-2:0] mono_ok;

  // a bit may only be set if every bit below it is set
  for (genvar g = 0; g < TW - 1; g++) begin : g_mono
    assign mono_ok[g] = !therm[g+1] || therm[g];
  end

  // priority toward the highest set bit
  always_comb begin
    code = '0;
    for (int i = 0; i < TW; i++) begin
      if (therm[i]) code = CW'(i + 1);
    end
  end

  always_comb begin
    // R2
    if (&mono_ok) begin
      enc_popcount_chk: assert (code == CW'($countones(therm)));
    end
  end
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pin_n;
  end

  assign fall = prev_q & ~pin_n;
  assign rise = ~prev_q & pin_n;
endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
  import hfadc_pkg::*;
#(
  parameter int unsigned TRACK_CYC = 150,
  parameter int unsigned FINE_CYC  = 150,
  localparam int unsigned CNT_MAX = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic cs_act,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic rd_fall,
  input  logic rd_rise,
  input  logic wr_fall,
  input  logic wr_rise,
  output logic hi_load,
  output logic lo_load,
  output logic busy,
  output logic rdy_pull,
  output logic int_n
);
  phase_e     ph;
  logic       conv_mode;
  logic [CNT_W-1:0] cnt;
  logic       start;

  always_comb begin
    start   = (ph == PH_IDLE) && cs_act && (mode_i ? wr_fall : rd_fall);
    hi_load = (ph == PH_TRACK) &&
              (conv_mode ? wr_rise : (cnt == CNT_W'(TRACK_CYC - 1)));
    lo_load = (ph == PH_FINE) &&
              ((cnt == CNT_W'(FINE_CYC - 1)) || (conv_mode && cs_act && rd_fall));
  end

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      conv_mode <= 1'b0;
      cnt       <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          cnt <= '0;
          if (start) begin
            ph        <= PH_TRACK;
            conv_mode <= mode_i;
          end
        end
        PH_TRACK: begin
          if (hi_load) begin
            ph  <= PH_FINE;
            cnt <= '0;
          end else if (!conv_mode) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FINE: begin
          if (lo_load) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_n    <= 1'b1;
      rdy_pull <= 1'b0;
    end else begin
      if (cs_rise || rd_rise) int_n <= 1'b1;
      if (lo_load)            int_n <= 1'b0;
      if (!mode_i && cs_fall) rdy_pull <= 1'b1;
      if (cs_rise || lo_load) rdy_pull <= 1'b0;
    end
  end

  // R5
  cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(CNT_MAX));

  // R4
  fine_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FINE && $past(ph) != PH_FINE) |-> $past(ph) == PH_TRACK);
endmodule

// File: rtl/hfadc_outreg.sv
module hfadc_outreg #(
  parameter int unsigned NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_load,
  input  logic               lo_load,
  input  logic [NIB_W-1:0]   hi_code,
  input  logic [NIB_W-1:0]   lo_code,
  input  logic               ovr_in,
  output logic [2*NIB_W-1:0] result,
  output logic               ovf
);
  logic [NIB_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      ovf  <= 1'b0;
    end else begin
      if (hi_load) hi_q <= hi_code;
      if (lo_load) begin
        lo_q <= lo_code;
        ovf  <= ovr_in;
      end
    end
  end

  assign result = {hi_q, lo_q};

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q != $past(hi_q)) |-> $past(hi_load));

  // R5
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q != $past(lo_q)) |-> $past(lo_load));
endmodule

// File: rtl/hfadc_ctrl.sv
module hfadc_ctrl
  import hfadc_pkg::*;
#(
  parameter int unsigned THERM_W   = 15,
  parameter int unsigned TRACK_CYC = 150,
  parameter int unsigned FINE_CYC  = 150,
  localparam int unsigned NIB_W  = $clog2(THERM_W + 1),
  localparam int unsigned DATA_W = 2 * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [THERM_W-1:0] coarse_therm,
  input  logic [THERM_W-1:0] fine_therm,
  input  logic               over_rng,
  output logic [DATA_W-1:0]  data,
  output logic               data_oe,
  output logic               int_n,
  output logic               rdy_pull,
  output logic               ovf
);
  logic [SB_N-1:0]  pins_n, falls, rises;
  logic [NIB_W-1:0] hi_code, lo_code;
  logic hi_load, lo_load, busy;

  assign pins_n[SB_CS] = cs_n;
  assign pins_n[SB_RD] = rd_n;
  assign pins_n[SB_WR] = wr_n;

  strobe_edge #(.N(SB_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (pins_n),
    .fall  (falls),
    .rise  (rises)
  );

  therm_enc #(.TW(THERM_W)) u_enc_coarse (.therm(coarse_therm), .code(hi_code));
  therm_enc #(.TW(THERM_W)) u_enc_fine   (.therm(fine_therm),   .code(lo_code));

  hfadc_seq #(.TRACK_CYC(TRACK_CYC), .FINE_CYC(FINE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .cs_act   (!cs_n),
    .cs_fall  (falls[SB_CS]),
    .cs_rise  (rises[SB_CS]),
    .rd_fall  (falls[SB_RD]),
    .rd_rise  (rises[SB_RD]),
    .wr_fall  (falls[SB_WR]),
    .wr_rise  (rises[SB_WR]),
    .hi_load  (hi_load),
    .lo_load  (lo_load),
    .busy     (busy),
    .rdy_pull (rdy_pull),
    .int_n    (int_n)
  );

  hfadc_outreg #(.NIB_W(NIB_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_load (hi_load),
    .lo_load (lo_load),
    .hi_code (hi_code),
    .lo_code (lo_code),
    .ovr_in  (over_rng),
    .result  (data),
    .ovf     (ovf)
  );

  assign data_oe = !cs_n && !rd_n;

  // R5
  int_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(busy));

  // R9
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_pull) |-> (!int_n || $past(cs_n)));
endmodule

// File: tb/test_hfadc_ctrl.sv
module test_hfadc_ctrl;
  localparam int TW  = 15;
  localparam int TRK = 150;
  localparam int FIN = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, over_rng = 1'b0;
  logic [TW-1:0] coarse = '0, fine = '0;
  logic [7:0] data;
  logic data_oe, int_n, rdy_pull, ovf;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];   // {ovf, byte}
  logic int_prev = 1'b1;

  always #2 clk = ~clk;

  hfadc_ctrl #(.THERM_W(TW), .TRACK_CYC(TRK), .FINE_CYC(FIN)) i_hfadc_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .coarse_therm(coarse), .fine_therm(fine), .over_rng(over_rng),
    .data(data), .data_oe(data_oe), .int_n(int_n), .rdy_pull(rdy_pull), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [TW-1:0] therm(input int n);
    return TW'(32'h7fff >> (TW - n));
  endfunction

  // driver side: queue the byte a conversion must produce
  task automatic expect_result(input logic o, input logic [7:0] b);
    exp_q.push_back({o, b});
  endtask

  // monitor: every completion pops one expected result
  always @(negedge clk) begin
    if (rst_n && int_prev && !int_n) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected completion", 1, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk("R2/R10 completed result", int'({ovf, data}), int'(e));
      end
    end
    int_prev = int_n;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    tick(5);
    // R1 reset state
    chk("R1 int_n", int'(int_n), 1);
    chk("R1 rdy_pull", int'(rdy_pull), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 data", int'(data), 0);
    chk("R3 oe idle", int'(data_oe), 0);
    rst_n = 1'b1;
    tick(2);

    // write-then-read with the internal delay
    mode = 1'b1; cs_n = 1'b0;
    coarse = therm(9); fine = therm(5); over_rng = 1'b0;
    tick(2);
    wr_n = 1'b0; tick(3);
    wr_n = 1'b1; expect_result(1'b0, 8'h95);
    tick(1);
    chk("R4 upper nibble latched at WR rise", int'(data[7:4]), 9);
    chk("R4 lower nibble held", int'(data[3:0]), 0);
    chk("R3 oe with rd high", int'(data_oe), 0);
    tick(FIN - 1);
    chk("R5 int before delay", int'(int_n), 1);
    tick(1);
    chk("R5 int at delay end", int'(int_n), 0);
    chk("R5 result byte", int'(data), 'h95);
    rd_n = 1'b0; #1;
    chk("R3 oe during read", int'(data_oe), 1);
    @(negedge clk);
    rd_n = 1'b1; tick(1);
    chk("R7 int cleared by RD rise", int'(int_n), 1);

    // early read cuts the fine phase; malformed fine code
    coarse = therm(15); fine = 15'h0043; over_rng = 1'b1;
    wr_n = 1'b0; tick(2);
    wr_n = 1'b1; tick(11);
    expect_result(1'b1, 8'hF7);
    rd_n = 1'b0; tick(1);
    chk("R6 early read completes", int'(int_n), 0);
    chk("R6 R2 malformed fine code", int'(data), 'hF7);
    chk("R10 ovf set", int'(ovf), 1);
    rd_n = 1'b1; tick(FIN + 5);
    chk("R6 no second completion", int'(int_n), 1);

    // completion cleared by CS rise
    coarse = therm(0); fine = therm(15); over_rng = 1'b0;
    wr_n = 1'b0; tick(2);
    wr_n = 1'b1; expect_result(1'b0, 8'h0F);
    tick(FIN + 1);
    chk("R5 int low", int'(int_n), 0);
    chk("R10 ovf cleared", int'(ovf), 0);
    cs_n = 1'b1; tick(1);
    chk("R7 int cleared by CS rise", int'(int_n), 1);

    // strobes ignored with CS high
    coarse = therm(4); fine = therm(4);
    wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(FIN + 10);
    chk("R12 no completion with CS high", int'(int_n), 1);
    chk("R12 data unchanged", int'(data), 'h0F);
    cs_n = 1'b0; tick(2);

    // tied strobes: pipelined operation
    coarse = therm(3); fine = therm(12);
    wr_n = 1'b0; rd_n = 1'b0; #1;
    chk("R11 previous result on bus", int'(data), 'h0F);
    chk("R3 oe on tied strobe", int'(data_oe), 1);
    @(negedge clk); tick(1);
    wr_n = 1'b1; rd_n = 1'b1; expect_result(1'b0, 8'h3C);
    tick(1);
    chk("R11 R4 new upper nibble", int'(data[7:4]), 3);
    tick(FIN);
    chk("R11 conversion done", int'(int_n), 0);
    coarse = therm(1); fine = therm(1);
    wr_n = 1'b0; rd_n = 1'b0; #1;
    chk("R11 second strobe shows previous", int'(data), 'h3C);
    @(negedge clk); tick(1);
    wr_n = 1'b1; rd_n = 1'b1; expect_result(1'b0, 8'h11);
    tick(1);
    chk("R7 tied strobe rise clears int", int'(int_n), 1);
    tick(FIN);
    chk("R11 second conversion byte", int'(data), 'h11);
    cs_n = 1'b1; tick(2);

    // read-only mode
    mode = 1'b0;
    coarse = therm(12); fine = therm(6); over_rng = 1'b1;
    tick(1);
    cs_n = 1'b0; rd_n = 1'b0; expect_result(1'b1, 8'hC6);
    tick(1);
    chk("R9 rdy pulled on CS fall", int'(rdy_pull), 1);
    chk("R7 int high at start", int'(int_n), 1);
    tick(TRK - 1);
    chk("R8 upper not yet latched", int'(data[7:4]), 1);
    tick(1);
    chk("R8 upper latched after track", int'(data[7:4]), 'hC);
    tick(FIN - 1);
    chk("R8 not yet done", int'(int_n), 1);
    chk("R9 rdy still low", int'(rdy_pull), 1);
    tick(1);
    chk("R8 completion", int'(int_n), 0);
    chk("R9 rdy released at completion", int'(rdy_pull), 0);
    chk("R10 ovf in read mode", int'(ovf), 1);
    rd_n = 1'b1; tick(1);
    cs_n = 1'b1; tick(1);

    // read-only mode: RD with CS high ignored, RDY released by CS rise
    rd_n = 1'b0; tick(TRK + FIN + 5);
    chk("R12 read mode no start", int'(int_n), 1);
    chk("R12 read mode data kept", int'(data), 'hC6);
    chk("R9 no rdy without CS", int'(rdy_pull), 0);
    rd_n = 1'b1; tick(1);
    cs_n = 1'b0; tick(1);
    chk("R9 rdy on CS fall", int'(rdy_pull), 1);
    tick(3);
    cs_n = 1'b1; tick(1);
    chk("R9 rdy released on CS rise", int'(rdy_pull), 0);
    tick(2);

    chk("R5 all expected results seen", exp_q.size(), 0);
    summary();
  end
endmodule